// File: doc/BRIEF.md
# Fractional-prescaled PWM base timer

This block is the shared time base for a group of PWM channels. One 32-bit control word sets it up: which tick source drives it, a fixed-point divisor with ten integer bits and eight fraction bits, the counter resolution, and two run controls, pause and hold-at-zero. The control word is loaded by a plain write strobe and read back at any time.

The tick source is either every system clock or an external reference strobe, which is synchronous to the system clock. The prescaler stretches the tick by the divisor. When the fraction is nonzero it mixes periods of the integer length and the integer length plus one, so the mean period equals the divisor. Each prescaled tick advances a counter that spans 2^N values. On the tick that wraps the counter, a single-cycle overflow pulse is raised for the comparator stage downstream. There is no data stream, so every pin is plain control or status.

Top module: `pwmt_base_timer`

## Requirements
- R1: `cfg_rdata` returns the control word. It is 0x0100_0000 after `rst_n` and holds the value of `cfg_wdata` from the first clock edge at which `cfg_we` is high.
- R2: While control bit 24 (hold) is 1, the counter reads 0 from the next clock on, and the prescale count and fraction accumulator are cleared. After `rst_n` the counter reads 0.
- R3: While control bit 23 (pause) is 1 and bit 24 is 0, the counter, the prescale count and the accumulator keep their values.
- R4: Control bit 25 selects the tick. A value of 1 gives a tick on every clock. A value of 0 gives a tick only on cycles where `ref_strobe` is 1.
- R5: Control bits [22:13] hold the integer divisor I and bits [12:5] hold the fraction F. Each prescaled period lasts I ticks, plus one more tick when adding F to an 8-bit accumulator carries out. The accumulator takes the 8-bit sum at the end of each period.
- R6: An integer divisor of 0 behaves as 1.
- R7: Control bits [4:0] hold N. The counter advances by one per prescaled tick over 0 to 2^N-1 and then returns to 0. Any N above 20 acts as 20.
- R8: `ovf_pulse` is 1 for exactly the cycle in which the counter has just wrapped to 0, and 0 otherwise.
- R9: A change of N truncates the live counter value to the new width from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the control word |
| cfg_wdata | input | 32 | New control word |
| cfg_rdata | output | 32 | Current control word |
| ref_strobe | input | 1 | Reference tick, one clock wide per tick |
| cnt_value | output | 20 | Timer count |
| ovf_pulse | output | 1 | One-cycle wrap indication |

## Verification
The bench aims at the fractional sequencing. With I=2 and F=0x80 and a two-value counter, wraps must come exactly five cycles apart. A design that applies the carry to the wrong period, or drops it, gives gaps of 4 or 6. A zero integer divisor with N=0 must overflow on every clock, where a stalling divider would never pulse. Random control words cover N above 20, where a missing clamp lets the count exceed 20 bits or alias. They also cover live resolution changes, where missing truncation leaves a count above the new range. Pause and hold windows expose designs that let the prescaler run on or fail to clear its accumulator.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int CTRL_W    = 32;
  localparam int RES_W     = 5;
  localparam int FRAC_W    = 8;
  localparam int INT_W     = 10;
  localparam int CNT_W_MAX = 20;
  localparam int RES_LSB   = 0;
  localparam int FRAC_LSB  = RES_LSB + RES_W;
  localparam int INT_LSB   = FRAC_LSB + FRAC_W;
  localparam int PAUSE_BIT = INT_LSB + INT_W;
  localparam int HOLD_BIT  = PAUSE_BIT + 1;
  localparam int SRC_BIT   = HOLD_BIT + 1;
  localparam int CFG_W     = SRC_BIT + 1;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 32'h0100_0000;

  typedef struct packed {
    logic              src_fast;
    logic              hold;
    logic              pause;
    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] div_frac;
    logic [RES_W-1:0]  res;
  } tcfg_t;
endpackage

// File: rtl/pwmt_ctrl_reg.sv
module pwmt_ctrl_reg
  import pwmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output tcfg_t             cfg
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= CTRL_RESET;
    else if (we) ctrl_q <= wdata;
  end

  assign rdata = ctrl_q;
  assign cfg   = tcfg_t'(ctrl_q[CFG_W-1:0]);
endmodule

// File: rtl/pwmt_tick_sel.sv
module pwmt_tick_sel (
  input  logic src_fast,
  input  logic ref_strobe,
  output logic tick_en
);
  assign tick_en = src_fast | ref_strobe;
endmodule

// File: rtl/pwmt_frac_div.sv
module pwmt_frac_div #(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic              tick_en,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              div_tick
);
  localparam int LEN_W = INT_W + 1;

  logic [LEN_W-1:0]  presc_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic [INT_W-1:0]  int_eff;
  logic [LEN_W-1:0]  period_len;
  logic [LEN_W-1:0]  presc_inc;
  logic              advance;

  assign int_eff    = (div_int == '0) ? INT_W'(1) : div_int;
  assign sum        = {1'b0, acc_q} + {1'b0, div_frac};
  assign period_len = {1'b0, int_eff} + LEN_W'(sum[FRAC_W]);
  assign presc_inc  = presc_q + LEN_W'(1);
  assign advance    = !clear && run && tick_en;
  assign div_tick   = advance && (presc_inc >= period_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      acc_q   <= '0;
    end else if (clear) begin
      presc_q <= '0;
      acc_q   <= '0;
    end else if (div_tick) begin
      presc_q <= '0;
      acc_q   <= sum[FRAC_W-1:0];
    end else if (advance) begin
      presc_q <= presc_inc;
    end
  end
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int CNT_W = 20,
  parameter int RES_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [RES_W-1:0] res,
  output logic [CNT_W-1:0] count,
  output logic             wrap_pulse
);
  logic [RES_W-1:0] res_eff;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] live;
  logic             at_top;
  logic             wrap_q;

  assign res_eff = (res > RES_W'(CNT_W)) ? RES_W'(CNT_W) : res;

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask[i] = (RES_W'(i) < res_eff);
  end

  assign live   = cnt_q & mask;
  assign at_top = (live == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (clear) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= step && at_top;
      if (step) cnt_q <= at_top ? '0 : live + CNT_W'(1);
      else      cnt_q <= live;
    end
  end

  assign count      = live;
  assign wrap_pulse = wrap_q;
endmodule

// File: rtl/pwmt_base_timer.sv
module pwmt_base_timer
  import pwmt_pkg::*;
#(
  parameter int CNT_W = CNT_W_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  input  logic              ref_strobe,
  output logic [CNT_W-1:0]  cnt_value,
  output logic              ovf_pulse
);
  tcfg_t cfg;
  logic  tick_en;
  logic  div_tick;

  pwmt_ctrl_reg i_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  pwmt_tick_sel i_tick (
    .src_fast   (cfg.src_fast),
    .ref_strobe (ref_strobe),
    .tick_en    (tick_en)
  );

  pwmt_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cfg.hold),
    .run      (!cfg.pause),
    .tick_en  (tick_en),
    .div_int  (cfg.div_int),
    .div_frac (cfg.div_frac),
    .div_tick (div_tick)
  );

  pwmt_counter #(.CNT_W(CNT_W), .RES_W(RES_W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (cfg.hold),
    .step       (div_tick),
    .res        (cfg.res),
    .count      (cnt_value),
    .wrap_pulse (ovf_pulse)
  );
endmodule

// File: rtl/pwmt_base_timer_chk.sv
module pwmt_base_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        ref_strobe,
  input logic [19:0] cnt_value,
  input logic        ovf_pulse
);
  logic [4:0] n_eff;
  assign n_eff = (cfg_rdata[4:0] > 5'd20) ? 5'd20 : cfg_rdata[4:0];

  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata)); // R1
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[24] |=> cnt_value == '0); // R2
  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[23] && !cfg_rdata[24]) |=> (cfg_rdata != $past(cfg_rdata) || $stable(cnt_value))); // R3
  AST_SLOW_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[25] && !ref_strobe) |=> !ovf_pulse); // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_value} < (21'd1 << n_eff)); // R7
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> cnt_value == '0); // R8
endmodule

bind pwmt_base_timer pwmt_base_timer_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .ref_strobe (ref_strobe),
  .cnt_value  (cnt_value),
  .ovf_pulse  (ovf_pulse)
);

// File: tb/test_pwmt_base_timer.sv
module test_pwmt_base_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ref_strobe = 1'b0;
  logic [19:0] cnt_value;
  logic        ovf_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R2";

  // bench model state
  logic [31:0] m_ctrl = 32'h0100_0000;
  int m_cnt = 0, m_presc = 0, m_acc = 0;
  bit m_ovf = 0;

  always #2.5 clk = ~clk;

  pwmt_base_timer i_pwmt_base_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ref_strobe(ref_strobe),
    .cnt_value(cnt_value), .ovf_pulse(ovf_pulse)
  );

  function automatic int top_of(logic [31:0] c);
    int n;
    n = (c[4:0] > 20) ? 20 : int'(c[4:0]);
    return (1 << n) - 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 32'h0100_0000; m_cnt = 0; m_presc = 0; m_acc = 0; m_ovf = 0;
    end else begin
      int mx, c, ie, s, len;
      bit tk, dt;
      mx = top_of(m_ctrl);
      c  = m_cnt & mx;
      tk = m_ctrl[25] ? 1'b1 : ref_strobe;
      if (m_ctrl[24]) begin
        m_cnt = 0; m_presc = 0; m_acc = 0; m_ovf = 0;
      end else begin
        dt = 0;
        if (!m_ctrl[23] && tk) begin
          ie  = (m_ctrl[22:13] == 0) ? 1 : int'(m_ctrl[22:13]);
          s   = m_acc + int'(m_ctrl[12:5]);
          len = ie + (s >> 8);
          if (m_presc + 1 >= len) begin
            dt = 1; m_presc = 0; m_acc = s & 255;
          end else m_presc = m_presc + 1;
        end
        m_ovf = dt && (c == mx);
        m_cnt = dt ? ((c == mx) ? 0 : c + 1) : c;
      end
      if (cfg_we) m_ctrl = cfg_wdata;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) if (rst_n) begin
    cycles++;
    check({tag, " count"}, int'(cnt_value), m_cnt & top_of(m_ctrl));
    check({tag, " R8 overflow"}, int'(ovf_pulse), int'(m_ovf));
  end

  task automatic write_cfg(logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mk(bit src, bit hold, bit pause, int di, int df, int n);
    return {6'd0, src, hold, pause, di[9:0], df[7:0], n[4:0]};
  endfunction

  task automatic wait_ovf(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!ovf_pulse && gap < 100);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int gap, hold_v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset word", int'(cfg_rdata), 32'h0100_0000);
    check("R2 reset count", int'(cnt_value), 0);

    // R1: write visible after the next edge
    tag = "R1";
    write_cfg(mk(1, 1, 0, 2, 8'h80, 1));
    check("R1 readback", int'(cfg_rdata), int'(mk(1, 1, 0, 2, 8'h80, 1)));

    // R5: I=2 F=0x80 N=1 -> wraps every 5 clocks
    tag = "R5";
    write_cfg(mk(1, 0, 0, 2, 8'h80, 1));
    wait_ovf(gap);
    for (int k = 0; k < 3; k++) begin
      wait_ovf(gap);
      check("R5 wrap gap", gap, 5);
    end

    // R6: I=0 F=0 N=0 -> overflow every clock
    tag = "R6";
    write_cfg(mk(1, 1, 0, 0, 0, 0));
    write_cfg(mk(1, 0, 0, 0, 0, 0));
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R6 every-clock overflow", int'(ovf_pulse), 1);
    end

    // R3: pause freezes count
    tag = "R3";
    write_cfg(mk(1, 0, 0, 1, 0, 8));
    repeat (7) @(negedge clk);
    write_cfg(mk(1, 0, 1, 1, 0, 8));
    hold_v = int'(cnt_value);
    repeat (10) @(negedge clk);
    check("R3 paused count", int'(cnt_value), hold_v);

    // R9: shrink N truncates
    tag = "R9";
    write_cfg(mk(1, 0, 1, 1, 0, 2));
    check("R9 truncated", int'(cnt_value), hold_v & 3);

    // R2: hold bit clears
    tag = "R2";
    write_cfg(mk(1, 1, 0, 1, 0, 8));
    @(negedge clk);
    check("R2 hold zero", int'(cnt_value), 0);

    // R4: slow source with sparse strobes
    tag = "R4";
    write_cfg(mk(0, 0, 0, 1, 0, 20));
    for (int k = 0; k < 40; k++) begin
      ref_strobe = (k % 3 == 0);
      @(negedge clk);
    end
    ref_strobe = 1'b0;
    check("R4 strobe count", int'(cnt_value), 14);

    // R7: clamp N=31 at 20, random mixes of all fields
    tag = "R5/R7/R9";
    for (int blk = 0; blk < 300; blk++) begin
      logic [31:0] w;
      w = $urandom;
      w[22:13] = 10'($urandom_range(0, 3));
      w[23] = ($urandom_range(0, 7) == 0);
      w[24] = ($urandom_range(0, 9) == 0);
      write_cfg(w);
      for (int k = 0; k < 20; k++) begin
        ref_strobe = $urandom_range(0, 1);
        @(negedge clk);
      end
    end
    ref_strobe = 1'b0;

    // R7: near-full count under clamp, check wrap
    tag = "R7";
    write_cfg(mk(1, 1, 0, 1, 0, 3));
    write_cfg(mk(1, 0, 0, 1, 0, 3));
    wait_ovf(gap);
    wait_ovf(gap);
    check("R7 period 2^3", gap, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule